// File: doc/BRIEF.md
# Key-Armed Machine-Cycle Watchdog

This block is a recovery timer for a small 8-bit controller. It starts out dormant. Software turns it on by writing a two-byte unlock key to one write-only register address on the controller's register bus. While it runs, each machine-cycle tick advances a private counter. Software must repeat the same two-byte key often enough to restart that counter. If the counter reaches its all-ones value, the block drives an active-high reset pulse. The pulse length depends on whether the controller runs six or twelve oscillator clocks per machine cycle.

Once on, the watchdog cannot be switched off by software. Only the external hardware reset or the block's own overflow pulse returns it to the dormant state. The bus side is a plain write strobe that always accepts, so it has no valid/ready handshake and no back-pressure. Reset-out is a level output. Neither the key register nor the counter can be read.

Top module: `key_wdt`

## Requirements
- R1: While and after `hw_rst` is high, `rst_out` is low and the watchdog is dormant. With no key written, any number of ticks produces no pulse.
- R2: A write of 0x1E followed by a write of 0xE1, both to address 0xA6 with `wr_en` high, arms the watchdog with its count at zero.
- R3: A write of 0xE1 to 0xA6 arms nothing unless 0x1E was the last value written to 0xA6. Any value other than 0x1E written to 0xA6 drops a pending first key byte. Repeating 0x1E keeps it pending.
- R4: Writes to any address other than 0xA6 leave a pending first key byte untouched, whatever their data.
- R5: Once armed, no bus write disarms the watchdog. Only an overflow or `hw_rst` clears it.
- R6: While armed, the count rises by one at each clock edge where `tick` is high. When it holds 2^CNT_W-1 (16383 by default), `rst_out` rises at the next clock edge, whether or not a tick is present.
- R7: A complete key sequence while armed returns the count to zero. A tick in the same cycle as the completing write is discarded.
- R8: The pulse lasts PULSE_FAST clock cycles (default 98) when `mode_slow` is 0 at overflow, and PULSE_SLOW clock cycles (default 196) when it is 1.
- R9: During and after the pulse the watchdog is dormant with no pending key byte. Key writes made while `rst_out` is high are ignored.
- R10: `hw_rst` clears all state asynchronously and ends a pulse in progress at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| hw_rst | input | 1 | Asynchronous active-high hardware reset |
| tick | input | 1 | One-clock machine-cycle strobe |
| mode_slow | input | 1 | 1 selects twelve-clock mode (long pulse), 0 selects six-clock mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rst_out | output | 1 | Active-high reset pulse on overflow |

## Verification
The bench builds the block with CNT_W=4, PULSE_FAST=5 and PULSE_SLOW=9. With these values an overflow takes only fifteen ticks, which allows a full sweep. The bench tries all 256 second-byte values and all 255 foreign addresses that could break a pending key. It also services the watchdog at every possible count and measures pulse widths in both modes. The smaller counter and pulse widths change only how long things take; the key decoding and the state transitions stay the same as at the default sizes.

// File: rtl/key_wdt_pkg.sv
package key_wdt_pkg;
  typedef enum logic {
    KEY_IDLE = 1'b0,
    KEY_HALF = 1'b1
  } key_st_e;
endpackage

// File: rtl/key_wdt_seq.sv
module key_wdt_seq
  import key_wdt_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  KEY_ADDR = 8'hA6,
  parameter logic [7:0]  KEY_LO   = 8'h1E,
  parameter logic [7:0]  KEY_HI   = 8'hE1
) (
  input  logic              clk,
  input  logic              hw_rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              key_hit,
  output logic              pend
);
  localparam logic [ADDR_W-1:0] ADDR_M = ADDR_W'(KEY_ADDR);
  localparam logic [DATA_W-1:0] LO_M   = DATA_W'(KEY_LO);
  localparam logic [DATA_W-1:0] HI_M   = DATA_W'(KEY_HI);

  key_st_e st_q;
  logic    sel;

  assign sel     = wr_en && (wr_addr == ADDR_M) && !clr;
  assign key_hit = sel && (st_q == KEY_HALF) && (wr_data == HI_M);
  assign pend    = (st_q == KEY_HALF);

  always_ff @(posedge clk or posedge hw_rst) begin
    if (hw_rst)                st_q <= KEY_IDLE;
    else if (clr)              st_q <= KEY_IDLE;
    else if (sel) begin
      if (wr_data == LO_M)     st_q <= KEY_HALF;
      else                     st_q <= KEY_IDLE;
    end
  end
endmodule

// File: rtl/key_wdt_count.sv
module key_wdt_count #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             hw_rst,
  input  logic             clr,
  input  logic             key_hit,
  input  logic             tick,
  output logic             en_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assign ovf = en_q && (cnt_q == CNT_MAX);

  always_ff @(posedge clk or posedge hw_rst) begin
    if (hw_rst) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (clr) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (key_hit) begin
      en_q  <= 1'b1;
      cnt_q <= '0;
    end else if (en_q && tick && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/key_wdt_pulse.sv
module key_wdt_pulse #(
  parameter int PULSE_FAST = 98,
  parameter int PULSE_SLOW = 196
) (
  input  logic clk,
  input  logic hw_rst,
  input  logic fire,
  input  logic mode_slow,
  output logic busy
);
  localparam int LEN_W = $clog2(PULSE_SLOW + 1);
  localparam logic [LEN_W-1:0] LEN_F = LEN_W'(PULSE_FAST);
  localparam logic [LEN_W-1:0] LEN_S = LEN_W'(PULSE_SLOW);

  logic [LEN_W-1:0] left_q;

  assign busy = (left_q != '0);

  always_ff @(posedge clk or posedge hw_rst) begin
    if (hw_rst)      left_q <= '0;
    else if (fire)   left_q <= mode_slow ? LEN_S : LEN_F;
    else if (busy)   left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/key_wdt.sv
module key_wdt #(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 8,
  parameter int          CNT_W      = 14,
  parameter int          PULSE_FAST = 98,
  parameter int          PULSE_SLOW = 196,
  parameter logic [7:0]  KEY_ADDR   = 8'hA6,
  parameter logic [7:0]  KEY_LO     = 8'h1E,
  parameter logic [7:0]  KEY_HI     = 8'hE1
) (
  input  logic              clk,
  input  logic              hw_rst,
  input  logic              tick,
  input  logic              mode_slow,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rst_out
);
  logic             key_hit;
  logic             pend;
  logic             en_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf;
  logic             clr;

  assign clr = ovf || rst_out;

  key_wdt_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY_ADDR(KEY_ADDR), .KEY_LO(KEY_LO), .KEY_HI(KEY_HI)
  ) u_seq (
    .clk(clk), .hw_rst(hw_rst), .clr(clr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .key_hit(key_hit), .pend(pend)
  );

  key_wdt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .hw_rst(hw_rst), .clr(clr), .key_hit(key_hit), .tick(tick),
    .en_q(en_q), .cnt_q(cnt_q), .ovf(ovf)
  );

  key_wdt_pulse #(.PULSE_FAST(PULSE_FAST), .PULSE_SLOW(PULSE_SLOW)) u_pls (
    .clk(clk), .hw_rst(hw_rst), .fire(ovf), .mode_slow(mode_slow),
    .busy(rst_out)
  );
endmodule

// File: rtl/key_wdt_chk.sv
module key_wdt_chk #(
  parameter int CNT_W      = 14,
  parameter int PULSE_SLOW = 196
) (
  input logic             clk,
  input logic             hw_rst,
  input logic             tick,
  input logic             rst_out,
  input logic             key_hit,
  input logic             pend,
  input logic             en_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ovf
);
  localparam logic [CNT_W-1:0] CMAX    = {CNT_W{1'b1}};
  localparam logic [15:0]      RUN_MAX = 16'(PULSE_SLOW);

  logic [15:0] run_q;
  always_ff @(posedge clk or posedge hw_rst) begin
    if (hw_rst)       run_q <= '0;
    else if (rst_out) run_q <= run_q + 16'd1;
    else              run_q <= '0;
  end

  AST_NO_SELF_ARM: assert property (@(posedge clk) disable iff (hw_rst)
    (!en_q && !key_hit) |=> !en_q); // R3
  AST_STICKY_ARM: assert property (@(posedge clk) disable iff (hw_rst)
    en_q |=> (en_q || rst_out)); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (hw_rst)
    (en_q && tick && !key_hit && cnt_q != CMAX) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R6
  AST_FIRE_AFTER_FULL: assert property (@(posedge clk) disable iff (hw_rst)
    (en_q && cnt_q == CMAX) |=> rst_out); // R6
  AST_SERVICE_ZERO: assert property (@(posedge clk) disable iff (hw_rst)
    key_hit |=> (en_q && cnt_q == '0)); // R7
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (hw_rst)
    run_q <= RUN_MAX); // R8
  AST_DORMANT_IN_PULSE: assert property (@(posedge clk) disable iff (hw_rst)
    $past(rst_out) |-> (!en_q && !pend)); // R9
  AST_ONLY_ARMED_FIRES: assert property (@(posedge clk) disable iff (hw_rst)
    $rose(rst_out) |-> $past(ovf)); // R6
endmodule

bind key_wdt key_wdt_chk #(.CNT_W(CNT_W), .PULSE_SLOW(PULSE_SLOW)) u_chk (
  .clk(clk), .hw_rst(hw_rst), .tick(tick), .rst_out(rst_out),
  .key_hit(key_hit), .pend(pend), .en_q(en_q), .cnt_q(cnt_q), .ovf(ovf)
);

// File: tb/sim_key_wdt.sv
module sim_key_wdt;
  localparam int CW   = 4;
  localparam int MAXC = (1 << CW) - 1;
  localparam int PF   = 5;
  localparam int PS   = 9;

  logic       clk = 1'b0;
  logic       hw_rst = 1'b1;
  logic       tick = 1'b0;
  logic       mode_slow = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rst_out;

  int n_chk = 0;
  int n_bad = 0;
  int hi_cnt = 0;

  always #10 clk = ~clk;

  key_wdt #(.CNT_W(CW), .PULSE_FAST(PF), .PULSE_SLOW(PS)) u0 (
    .clk(clk), .hw_rst(hw_rst), .tick(tick), .mode_slow(mode_slow),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rst_out(rst_out)
  );

  always @(negedge clk) if (rst_out) hi_cnt = hi_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_rst();
    @(negedge clk); hw_rst = 1'b1;
    @(negedge clk); hw_rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  // ticks to overflow and reports whether a pulse appeared, then lets it end
  task automatic probe(output bit fired);
    hi_cnt = 0;
    do_ticks(MAXC);
    repeat (3) @(negedge clk);
    #1 fired = (hi_cnt != 0);
    repeat (PS + 2) @(negedge clk);
  endtask

  initial begin
    bit f;
    // R1 reset state
    #1 chk(rst_out == 1'b0, "R1 during reset", rst_out, 0);
    do_rst();
    #1 chk(rst_out == 1'b0, "R1 after reset", rst_out, 0);
    hi_cnt = 0;
    do_ticks(3 * MAXC);
    #1 chk(hi_cnt == 0, "R1 no key no pulse", hi_cnt, 0);

    // R2/R3 sweep of second key byte
    for (int d = 0; d < 256; d++) begin
      do_rst();
      wr(8'hA6, 8'h1E);
      wr(8'hA6, 8'(d));
      probe(f);
      chk(f == (d == 8'hE1), (d == 8'hE1) ? "R2 key arms" : "R3 wrong second byte", f, d == 8'hE1);
    end

    // R3 lone second byte, repeated first byte, broken pending
    do_rst(); wr(8'hA6, 8'hE1); probe(f);
    chk(f == 1'b0, "R3 lone E1", f, 0);
    do_rst(); wr(8'hA6, 8'h1E); wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1); probe(f);
    chk(f == 1'b1, "R3 repeated 1E", f, 1);
    do_rst(); wr(8'hA6, 8'h1E); wr(8'hA6, 8'h00); wr(8'hA6, 8'hE1); probe(f);
    chk(f == 1'b0, "R3 pending dropped", f, 0);

    // R4 foreign addresses keep pending
    for (int a = 0; a < 256; a++) begin
      if (a != 8'hA6) begin
        do_rst();
        wr(8'hA6, 8'h1E);
        wr(8'(a), (a % 2 == 0) ? 8'h00 : 8'hE1);
        wr(8'hA6, 8'hE1);
        probe(f);
        chk(f == 1'b1, "R4 foreign address", f, 1);
      end
    end

    // R5 writes after arming do not disarm
    do_rst(); wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    wr(8'hA6, 8'h00); wr(8'hA6, 8'h1E); wr(8'hA6, 8'h55); wr(8'h00, 8'h00);
    probe(f);
    chk(f == 1'b1, "R5 no software disarm", f, 1);

    // R6/R7 service at every count, exact overflow edge
    for (int s = 1; s < MAXC; s++) begin
      do_rst(); wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
      do_ticks(s);
      wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
      hi_cnt = 0;
      do_ticks(MAXC - 1);
      repeat (2) @(negedge clk);
      #1 chk(hi_cnt == 0, "R7 service restarts count", hi_cnt, 0);
      do_ticks(1);
      #1 chk(rst_out == 1'b0, "R6 not before next edge", rst_out, 0);
      @(negedge clk);
      #1 chk(rst_out == 1'b1, "R6 pulse on next edge", rst_out, 1);
      repeat (PS + 2) @(negedge clk);
    end

    // R7 tick coinciding with completing write is discarded
    do_rst(); wr(8'hA6, 8'h1E);
    @(negedge clk); wr_en = 1'b1; wr_addr = 8'hA6; wr_data = 8'hE1; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    hi_cnt = 0;
    do_ticks(MAXC - 1);
    repeat (2) @(negedge clk);
    #1 chk(hi_cnt == 0, "R7 coincident tick dropped", hi_cnt, 0);

    // R8 pulse width in both modes
    for (int m = 0; m < 2; m++) begin
      do_rst();
      mode_slow = m[0];
      wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
      hi_cnt = 0;
      do_ticks(MAXC);
      repeat (PS + 5) @(negedge clk);
      #1 chk(hi_cnt == (m ? PS : PF), "R8 pulse width", hi_cnt, m ? PS : PF);
    end
    mode_slow = 1'b1;

    // R9 dormant after pulse, key writes in pulse ignored
    do_rst(); wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    do_ticks(MAXC);
    @(negedge clk);
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1); wr(8'hA6, 8'h1E);
    repeat (PS) @(negedge clk);
    #1 chk(rst_out == 1'b0, "R9 pulse over", rst_out, 0);
    wr(8'hA6, 8'hE1);
    probe(f);
    chk(f == 1'b0, "R9 dormant after pulse", f, 0);

    // R10 hardware reset aborts pulse
    do_rst(); wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    do_ticks(MAXC);
    repeat (3) @(negedge clk);
    #1 chk(rst_out == 1'b1, "R10 pulse running", rst_out, 1);
    #2 hw_rst = 1'b1;
    #1 chk(rst_out == 1'b0, "R10 async abort", rst_out, 0);
    @(negedge clk); hw_rst = 1'b0;
    probe(f);
    chk(f == 1'b0, "R10 dormant after reset", f, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule